// File: doc/BRIEF.md
# Repeating RTC Alarm Comparator

This block is the alarm section of a battery-backed timekeeper. Software loads four alarm bytes (seconds, minutes, hours, day of month) through a byte-wide register port. Each byte holds a BCD value in its low bits and a mask flag in bit 7. A separate clock block supplies the running calendar counters as BCD inputs, together with a one-cycle strobe once per second. On each strobe the block compares the unmasked alarm fields with the counters. When they agree it raises a single-cycle interrupt pulse.

The mask flags form a cumulative pattern that sets the repeat rate. With no masks the alarm is monthly. Masking the date makes it daily. Masking date and hour makes it hourly. Masking date, hour and minute makes it fire every minute. Masking all four makes it fire every second. A write whose BCD value is outside the field's legal range is dropped, and the register keeps its old contents.

Top module: `alarm_top`

## Requirements
- R1: After reset all four alarm registers read 0x00 and `alarmIrq` is low.
- R2: Register address 0 is seconds, 1 is minutes, 2 is hours and 3 is date. A read returns the last accepted byte, mask bit 7 included.
- R3: A seconds or minutes write is accepted only if bits [6:4] are 0–5 and bits [3:0] are 0–9 (BCD 00–59). Any other write is ignored.
- R4: An hours write is accepted only if bits [5:0] are BCD 00–23. Any other write is ignored.
- R5: A date write is accepted only if bits [5:0] are BCD 01–31. Any other write is ignored.
- R6: With no mask bits set, a tick fires the alarm only when date, hour, minute and second all match.
- R7: With only the date mask set, a tick fires the alarm when hour, minute and second match, whatever the date.
- R8: With the date and hour masks set, a tick fires the alarm when minute and second match.
- R9: With the date, hour and minute masks set, a tick fires the alarm when the second matches.
- R10: With all four masks set, every tick fires the alarm. Any mask pattern other than the five named ones also fires on every tick.
- R11: `alarmIrq` is high for exactly the one clock cycle after a firing tick, and it never rises without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 sec, 1 min, 2 hour, 3 date) |
| regWdata | input | 8 | Write byte |
| regRdata | output | 8 | Read byte of the selected register (combinational) |
| secTick | input | 1 | One-cycle strobe, once per second |
| curSec | input | 7 | Current seconds, BCD |
| curMin | input | 7 | Current minutes, BCD |
| curHour | input | 6 | Current hours, BCD |
| curDate | input | 6 | Current day of month, BCD |
| alarmIrq | output | 1 | Alarm interrupt pulse |

## Verification
The assertions assume that `secTick` is a single-cycle pulse separated by idle cycles, as the clock block produces it. Under that assumption a firing pulse cannot last longer than one cycle. The bench drives every tick as one high cycle followed by at least two low cycles, and it changes the time inputs only on falling edges. The checks on accepted and rejected writes observe the read port while the address is held on the same register.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int FIELD_CNT = 4;
  localparam int SEC_IDX = 0;
  localparam int MIN_IDX = 1;
  localparam int HOUR_IDX = 2;
  localparam int DATE_IDX = 3;
  localparam int MASK_BIT = 7;

  typedef struct packed {
    logic [FIELD_CNT-1:0] wrEn;
    logic [FIELD_CNT-1:0] cmpEn;
    logic evalNow;
  } ctrlStrobes_t;

  function automatic logic [7:0] fieldMaskOf(input int idx);
    return (idx == SEC_IDX || idx == MIN_IDX) ? 8'h7F : 8'h3F;
  endfunction
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic                 secTick,
  input  logic [FIELD_CNT-1:0] maskBits,
  output ctrlStrobes_t         strobes
);
  logic [2:0] hiSec;
  logic [1:0] hiHd;
  logic [3:0] loDig;
  logic secOk;
  logic hourOk;
  logic dateOk;
  logic [FIELD_CNT-1:0] valid;

  assign hiSec = regWdata[6:4];
  assign hiHd = regWdata[5:4];
  assign loDig = regWdata[3:0];

  assign secOk = (hiSec <= 3'd5) && (loDig <= 4'd9);
  assign hourOk = (loDig <= 4'd9) && ((hiHd < 2'd2) || (hiHd == 2'd2 && loDig <= 4'd3));
  assign dateOk = (loDig <= 4'd9) && !(hiHd == 2'd0 && loDig == 4'd0)
                  && !(hiHd == 2'd3 && loDig > 4'd1);

  always_comb begin
    valid = '0;
    valid[SEC_IDX] = secOk;
    valid[MIN_IDX] = secOk;
    valid[HOUR_IDX] = hourOk;
    valid[DATE_IDX] = dateOk;
  end

  generate
    for (genvar i = 0; i < FIELD_CNT; i++) begin : g_wr
      assign strobes.wrEn[i] = regWe && (regAddr == ADDR_W'(i)) && valid[i];
    end
  endgenerate

  always_comb begin
    unique case (maskBits)
      4'b0000: strobes.cmpEn = 4'b1111;
      4'b1000: strobes.cmpEn = 4'b0111;
      4'b1100: strobes.cmpEn = 4'b0011;
      4'b1110: strobes.cmpEn = 4'b0001;
      default: strobes.cmpEn = 4'b0000;
    endcase
  end

  assign strobes.evalNow = secTick;
endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobes_t                      strobes,
  input  logic [DATA_W-1:0]                 regWdata,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [FIELD_CNT-1:0][DATA_W-1:0]  timeVec,
  output logic [DATA_W-1:0]                 regRdata,
  output logic [FIELD_CNT-1:0]              maskBits,
  output logic                              alarmIrq
);
  logic [FIELD_CNT-1:0][DATA_W-1:0] alarmRegs;
  logic [FIELD_CNT-1:0] matchVec;

  generate
    for (genvar i = 0; i < FIELD_CNT; i++) begin : g_field
      always_ff @(posedge clk) begin
        if (!rstN) alarmRegs[i] <= '0;
        else if (strobes.wrEn[i]) alarmRegs[i] <= regWdata;
      end
      assign maskBits[i] = alarmRegs[i][MASK_BIT];
      assign matchVec[i] = ((alarmRegs[i] & DATA_W'(fieldMaskOf(i))) == timeVec[i]);
    end
  endgenerate

  assign regRdata = alarmRegs[regAddr];

  always_ff @(posedge clk) begin
    if (!rstN) alarmIrq <= 1'b0;
    else alarmIrq <= strobes.evalNow && (&(matchVec | ~strobes.cmpEn));
  end
endmodule

// File: rtl/alarm_top.sv
module alarm_top
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              secTick,
  input  logic [6:0]        curSec,
  input  logic [6:0]        curMin,
  input  logic [5:0]        curHour,
  input  logic [5:0]        curDate,
  output logic              alarmIrq
);
  ctrlStrobes_t strobes;
  logic [FIELD_CNT-1:0] maskBits;
  logic [FIELD_CNT-1:0][DATA_W-1:0] timeVec;

  always_comb begin
    timeVec = '0;
    timeVec[SEC_IDX] = DATA_W'(curSec);
    timeVec[MIN_IDX] = DATA_W'(curMin);
    timeVec[HOUR_IDX] = DATA_W'(curHour);
    timeVec[DATE_IDX] = DATA_W'(curDate);
  end

  alarm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .secTick(secTick), .maskBits(maskBits), .strobes(strobes)
  );

  alarm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWdata(regWdata),
    .regAddr(regAddr), .timeVec(timeVec), .regRdata(regRdata),
    .maskBits(maskBits), .alarmIrq(alarmIrq)
  );
endmodule

// File: rtl/alarm_chk.sv
module alarm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWe,
  input logic [1:0] regAddr,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic       secTick,
  input logic       alarmIrq
);
  logic secLegal;
  logic hourLegal;
  assign secLegal = (regWdata[6:4] < 3'd6) && (regWdata[3:0] < 4'd10);
  assign hourLegal = (regWdata[3:0] < 4'd10) &&
                     (regWdata[5:4] == 2'd0 || regWdata[5:4] == 2'd1 ||
                      (regWdata[5:4] == 2'd2 && regWdata[3:0] < 4'd4));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !alarmIrq);

  // R11
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmIrq) |-> $past(secTick));

  // R11
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |=> !alarmIrq);

  // R3
  bad_sec_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd0 && !secLegal) ##1 (regAddr == 2'd0) |-> $stable(regRdata));

  // R4
  bad_hour_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd2 && !hourLegal) ##1 (regAddr == 2'd2) |-> $stable(regRdata));

  // R2
  good_sec_stored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd0 && secLegal) ##1 (regAddr == 2'd0) |-> regRdata == $past(regWdata));
endmodule

bind alarm_top alarm_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .regRdata(regRdata), .secTick(secTick), .alarmIrq(alarmIrq)
);

// File: tb/sim_alarm_top.sv
module sim_alarm_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic secTick = 1'b0;
  logic [6:0] curSec = '0;
  logic [6:0] curMin = '0;
  logic [5:0] curHour = '0;
  logic [5:0] curDate = '0;
  logic alarmIrq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  alarm_top u0 (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); regAddr = a;
    #1 chk(regRdata, exp, tag);
  endtask

  task automatic tickChk(input logic [5:0] d, input logic [5:0] h, input logic [6:0] m,
                         input logic [6:0] s, input logic exp, input string tag);
    @(negedge clk);
    curDate = d; curHour = h; curMin = m; curSec = s; secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    chk({7'd0, alarmIrq}, {7'd0, exp}, tag);
    @(negedge clk);
    chk({7'd0, alarmIrq}, 8'h00, {tag, " pulse end R11"});
  endtask

  task automatic testReset();
    for (int i = 0; i < 4; i++) rdChk(2'(i), 8'h00, "R1 reset value");
    chk({7'd0, alarmIrq}, 8'h00, "R1 irq low");
  endtask

  task automatic testWrites();
    wr(0, 8'h25); rdChk(0, 8'h25, "R2 sec write");
    wr(0, 8'h60); rdChk(0, 8'h25, "R3 sec 60 ignored");
    wr(1, 8'h5A); rdChk(1, 8'h00, "R3 min 5A ignored");
    wr(1, 8'hD9); rdChk(1, 8'hD9, "R2 min with mask");
    wr(2, 8'h24); rdChk(2, 8'h00, "R4 hour 24 ignored");
    wr(2, 8'h23); rdChk(2, 8'h23, "R4 hour 23 kept");
    wr(2, 8'h1A); rdChk(2, 8'h23, "R4 hour 1A ignored");
    wr(3, 8'h00); rdChk(3, 8'h00, "R5 date 00 ignored");
    wr(3, 8'h31); rdChk(3, 8'h31, "R5 date 31 kept");
    wr(3, 8'h32); rdChk(3, 8'h31, "R5 date 32 ignored");
  endtask

  task automatic testMonthly();
    wr(0, 8'h10); wr(1, 8'h20); wr(2, 8'h08); wr(3, 8'h15);
    tickChk(6'h15, 6'h08, 7'h20, 7'h10, 1'b1, "R6 monthly match");
    tickChk(6'h16, 6'h08, 7'h20, 7'h10, 1'b0, "R6 date differs");
    tickChk(6'h15, 6'h08, 7'h20, 7'h11, 1'b0, "R6 sec differs");
  endtask

  task automatic testDaily();
    wr(3, 8'h95);
    tickChk(6'h03, 6'h08, 7'h20, 7'h10, 1'b1, "R7 daily any date");
    tickChk(6'h03, 6'h09, 7'h20, 7'h10, 1'b0, "R7 hour differs");
  endtask

  task automatic testHourly();
    wr(2, 8'h88);
    tickChk(6'h03, 6'h05, 7'h20, 7'h10, 1'b1, "R8 hourly any hour");
    tickChk(6'h03, 6'h05, 7'h21, 7'h10, 1'b0, "R8 minute differs");
  endtask

  task automatic testMinute();
    wr(1, 8'hA0);
    tickChk(6'h07, 6'h13, 7'h44, 7'h10, 1'b1, "R9 minute repeat");
    tickChk(6'h07, 6'h13, 7'h44, 7'h11, 1'b0, "R9 second differs");
  endtask

  task automatic testEverySec();
    wr(0, 8'h90);
    tickChk(6'h01, 6'h00, 7'h00, 7'h59, 1'b1, "R10 all masked");
    wr(1, 8'h20); wr(2, 8'h08); wr(3, 8'h15);
    tickChk(6'h02, 6'h03, 7'h04, 7'h05, 1'b1, "R10 odd pattern acts per second");
  endtask

  task automatic testNoTick();
    @(negedge clk); curDate = 6'h15; curHour = 6'h08; curMin = 7'h20; curSec = 7'h10;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk({7'd0, alarmIrq}, 8'h00, "R11 no tick no irq");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrites();
    testMonthly();
    testDaily();
    testHourly();
    testMinute();
    testEverySec();
    testNoTick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule